// File: doc/BRIEF.md
# Three-Stage Fetch/Decode/Execute Pipeline Controller

This block sequences instructions through a fetch, decode and execute pipeline for a small RISC core that runs either 32-bit word instructions or 16-bit halfword instructions. It drives the instruction-memory address and captures the returned instruction into a decode register. One cycle later it moves that instruction into an execute register. For the instruction in execute, the block presents the instruction, its address, a stub opcode field and the PC value that the instruction reads. That PC value sits two fetch steps ahead of the instruction's own address.

When execute writes the PC (a taken branch or a direct PC write), the block discards the two younger instructions and restarts fetch at the target. The target is first aligned to the current instruction width. A one-cycle interrupt request is latched. The block acts on it at the next instruction boundary: the instruction in execute completes, fetch jumps to a fixed vector, and the address of the next instruction that would have executed is reported as the return address. A low instruction-memory ready freezes the whole pipeline.

Top module: `pipe3_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, no stage is valid (`ex_valid_o` low) and the fetch address `imem_addr_o` is 0.
- R2: With `imem_ready_i` high and no redirect, the fetch address rises by 4 each cycle when `half_mode_i` is 0 and by 2 when it is 1.
- R3: The instruction fetched at an address reaches execute two clock edges after that address is presented. Once the pipeline is full, a new instruction is in execute every cycle, and execute addresses rise by one fetch step per cycle.
- R4: `ex_pc_o` equals `ex_addr_o` + 8 for a word instruction and `ex_addr_o` + 4 for a halfword instruction.
- R5: `redirect_i` while an instruction completes in execute clears the decode and execute stages. The next fetch address is the target, execute is empty for two cycles, and the target instruction is in execute on the third cycle.
- R6: A redirect target is aligned to the current width: bits [1:0] are cleared in word mode, and bit 0 is cleared in halfword mode.
- R7: While `imem_ready_i` is low, the fetch address, the execute contents and all valid bits hold.
- R8: A one-cycle `irq_i` pulse is latched. It is taken (`irq_take_o` high) in the first cycle in which execute holds a valid instruction and `imem_ready_i` is high, but not before the pulse has been registered. On take, the executing instruction completes (`ex_done_o` high), the return address is `ex_addr_o` plus its width in bytes, the next fetch address is the vector address, and the younger stages are flushed.
- R9: An interrupt taken in the same cycle as a redirect reports the aligned redirect target as its return address, and fetch still goes to the vector.
- R10: `ex_done_o` is high exactly when execute holds a valid instruction and `imem_ready_i` is high. An instruction counts as processed only on that cycle.
- R11: A halfword instruction is taken from `imem_rdata_i[15:0]` and is presented zero-extended. The opcode stub is instruction bits [31:28] for a word instruction and bits [15:12] for a halfword instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_mode_i | input | 1 | 1 selects 16-bit instructions, 0 selects 32-bit instructions |
| imem_addr_o | output | 32 | Instruction fetch address |
| imem_rdata_i | input | 32 | Instruction returned for `imem_addr_o` in the same cycle |
| imem_ready_i | input | 1 | Memory ready; low stalls all stages |
| redirect_i | input | 1 | Execute writes the PC (taken branch or direct write) |
| redirect_target_i | input | 32 | New PC value from execute |
| irq_i | input | 1 | Interrupt request |
| ex_valid_o | output | 1 | Execute stage holds an instruction |
| ex_done_o | output | 1 | The execute instruction completes this cycle |
| ex_instr_o | output | 32 | Instruction in execute |
| ex_opcode_o | output | 4 | Stub opcode field of the execute instruction |
| ex_addr_o | output | 32 | Address of the execute instruction |
| ex_pc_o | output | 32 | PC value read by the execute instruction |
| irq_take_o | output | 1 | The interrupt is taken this cycle |
| irq_ret_addr_o | output | 32 | Return address saved by the interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and instructions, a 4-bit opcode stub, and the vector at 0x18. It runs the full sequence once in word mode and once in halfword mode. Because the memory model derives each instruction from its address, every execute address, PC value, instruction and opcode can be predicted by arithmetic. The redirect sweep covers all four low-bit patterns of the target, which exercises the alignment rule in both widths. The interrupt cases are set up to reach the take cycle directly, during a stall, and together with a redirect.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
    parameter int unsigned PIPE_AW    = 32;
    parameter int unsigned PIPE_IW    = 32;
    parameter int unsigned PIPE_OPC_W = 4;
    localparam int unsigned PIPE_HW   = PIPE_IW / 2;

    typedef logic [PIPE_AW-1:0] addr_t;
    typedef logic [PIPE_IW-1:0] instr_t;

    typedef struct packed {
        logic   valid;
        logic   half;
        instr_t instr;
        addr_t  addr;
    } stage_t;

    function automatic addr_t align_addr(input addr_t a, input logic half);
        addr_t r;
        r = a;
        r[0] = 1'b0;
        if (!half) r[1] = 1'b0;
        return r;
    endfunction

    function automatic addr_t step_of(input logic half);
        return half ? addr_t'(2) : addr_t'(4);
    endfunction
endpackage

// File: rtl/pipe3_fetch_addr.sv
module pipe3_fetch_addr
    import pipe3_pkg::*;
#(
    parameter addr_t VECTOR_ADDR = addr_t'(32'h18)
) (
    input  addr_t pc_q_i,
    input  logic  half_i,
    input  logic  redirect_i,
    input  addr_t target_i,
    input  logic  irq_take_i,
    output addr_t target_aligned_o,
    output addr_t pc_next_o
);
    always_comb begin
        target_aligned_o = align_addr(target_i, half_i);
        if (irq_take_i) begin
            pc_next_o = VECTOR_ADDR;
        end else if (redirect_i) begin
            pc_next_o = target_aligned_o;
        end else begin
            pc_next_o = pc_q_i + step_of(half_i);
        end
    end
endmodule

// File: rtl/pipe3_irq_ctl.sv
module pipe3_irq_ctl
    import pipe3_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  irq_i,
    input  logic  ex_valid_i,
    input  logic  ready_i,
    input  logic  ex_half_i,
    input  addr_t ex_addr_i,
    input  logic  redirect_i,
    input  addr_t target_aligned_i,
    output logic  take_o,
    output addr_t ret_addr_o
);
    logic pend_d, pend_q;

    always_comb begin
        take_o     = pend_q & ex_valid_i & ready_i;
        pend_d     = (pend_q | irq_i) & ~take_o;
        ret_addr_o = redirect_i ? target_aligned_i : ex_addr_i + step_of(ex_half_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    // R8: a latched request is not dropped until it is taken
    assert_pending_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !(ex_valid_i && ready_i)) |=> pend_q);
    // R8: a request arriving is remembered
    assert_pending_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> pend_q);
endmodule

// File: rtl/pipe3_ctrl.sv
module pipe3_ctrl
    import pipe3_pkg::*;
#(
    parameter addr_t VECTOR_ADDR = addr_t'(32'h18)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  half_mode_i,
    output logic [PIPE_AW-1:0]    imem_addr_o,
    input  logic [PIPE_IW-1:0]    imem_rdata_i,
    input  logic                  imem_ready_i,
    input  logic                  redirect_i,
    input  logic [PIPE_AW-1:0]    redirect_target_i,
    input  logic                  irq_i,
    output logic                  ex_valid_o,
    output logic                  ex_done_o,
    output logic [PIPE_IW-1:0]    ex_instr_o,
    output logic [PIPE_OPC_W-1:0] ex_opcode_o,
    output logic [PIPE_AW-1:0]    ex_addr_o,
    output logic [PIPE_AW-1:0]    ex_pc_o,
    output logic                  irq_take_o,
    output logic [PIPE_AW-1:0]    irq_ret_addr_o
);
    typedef struct packed {
        addr_t  pc;
        stage_t dec;
        stage_t ex;
    } pipe_state_t;

    pipe_state_t st_d, st_q;
    logic  ex_done, redir_ok, flush;
    addr_t pc_next, tgt_aligned;
    instr_t fetched;

    assign ex_done  = st_q.ex.valid & imem_ready_i;
    assign redir_ok = ex_done & redirect_i;
    assign flush    = redir_ok | irq_take_o;

    pipe3_fetch_addr #(.VECTOR_ADDR(VECTOR_ADDR)) u_fetch (
        .pc_q_i           (st_q.pc),
        .half_i           (half_mode_i),
        .redirect_i       (redir_ok),
        .target_i         (redirect_target_i),
        .irq_take_i       (irq_take_o),
        .target_aligned_o (tgt_aligned),
        .pc_next_o        (pc_next)
    );

    pipe3_irq_ctl u_irq (
        .clk              (clk),
        .rst_n            (rst_n),
        .irq_i            (irq_i),
        .ex_valid_i       (st_q.ex.valid),
        .ready_i          (imem_ready_i),
        .ex_half_i        (st_q.ex.half),
        .ex_addr_i        (st_q.ex.addr),
        .redirect_i       (redir_ok),
        .target_aligned_i (tgt_aligned),
        .take_o           (irq_take_o),
        .ret_addr_o       (irq_ret_addr_o)
    );

    always_comb begin
        fetched = half_mode_i ? {{(PIPE_IW-PIPE_HW){1'b0}}, imem_rdata_i[PIPE_HW-1:0]}
                              : imem_rdata_i;
        st_d = st_q;
        if (imem_ready_i) begin
            st_d.pc        = pc_next;
            st_d.ex        = st_q.dec;
            st_d.dec.valid = 1'b1;
            st_d.dec.half  = half_mode_i;
            st_d.dec.instr = fetched;
            st_d.dec.addr  = st_q.pc;
            if (flush) begin
                st_d.ex.valid  = 1'b0;
                st_d.dec.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        imem_addr_o = st_q.pc;
        ex_valid_o  = st_q.ex.valid;
        ex_done_o   = ex_done;
        ex_instr_o  = st_q.ex.instr;
        ex_addr_o   = st_q.ex.addr;
        ex_pc_o     = st_q.ex.addr + (step_of(st_q.ex.half) << 1);
        ex_opcode_o = st_q.ex.half ? st_q.ex.instr[PIPE_HW-1 -: PIPE_OPC_W]
                                   : st_q.ex.instr[PIPE_IW-1 -: PIPE_OPC_W];
    end

    // R7: stall freezes the pipeline
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !imem_ready_i |=> ($stable(st_q.pc) && $stable(st_q.ex.valid) &&
                           $stable(st_q.dec.valid) && $stable(st_q.ex.addr)));
    // R5: redirect empties the younger stages
    assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_done && redirect_i) |=> (!st_q.dec.valid && !st_q.ex.valid));
    // R2: sequential fetch step
    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_ready_i && !(ex_done && redirect_i) && !irq_take_o) |=>
        (st_q.pc == $past(st_q.pc) + step_of($past(half_mode_i))));
    // R8: interrupt jumps to the vector and only at a completing boundary
    assert_irq_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |=> (st_q.pc == VECTOR_ADDR && !st_q.ex.valid));
    assert_irq_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> ex_done_o);
endmodule

// File: tb/pipe3_ctrl_tb.sv
module pipe3_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_mode = 1'b0;
    logic [31:0] imem_addr, imem_rdata;
    logic        imem_ready = 1'b1;
    logic        redirect = 1'b0;
    logic [31:0] redirect_target = '0;
    logic        irq = 1'b0;
    logic        ex_valid, ex_done, irq_take;
    logic [31:0] ex_instr, ex_addr, ex_pc, irq_ret;
    logic [3:0]  ex_opcode;

    int total = 0;
    int bad = 0;
    localparam logic [31:0] VEC = 32'h18;

    always #2 clk = ~clk;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0] ^ 16'h1E7B};
    endfunction

    function automatic logic [31:0] alignf(input logic [31:0] a, input logic hm);
        return hm ? (a & ~32'h1) : (a & ~32'h3);
    endfunction

    assign imem_rdata = memf(imem_addr);

    pipe3_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .half_mode_i(half_mode),
        .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata), .imem_ready_i(imem_ready),
        .redirect_i(redirect), .redirect_target_i(redirect_target), .irq_i(irq),
        .ex_valid_o(ex_valid), .ex_done_o(ex_done), .ex_instr_o(ex_instr),
        .ex_opcode_o(ex_opcode), .ex_addr_o(ex_addr), .ex_pc_o(ex_pc),
        .irq_take_o(irq_take), .irq_ret_addr_o(irq_ret)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_exec(input string req, input logic [31:0] a, input logic hm);
        logic [31:0] m;
        m = memf(a);
        chk({req, " ex_valid"}, 32'(ex_valid), 32'd1);
        chk({req, " ex_addr"}, ex_addr, a);
        chk("R4 ex_pc", ex_pc, a + (hm ? 32'd4 : 32'd8));
        chk("R11 instr", ex_instr, hm ? {16'h0, m[15:0]} : m);
        chk("R11 opcode", 32'(ex_opcode), 32'(hm ? m[15:12] : m[31:28]));
        chk("R10 done", 32'(ex_done), 32'(imem_ready));
    endtask

    task automatic run_mode(input logic hm);
        logic [31:0] st, a0, f0, t, ta;
        st = hm ? 32'd2 : 32'd4;
        rst_n = 1'b0; half_mode = hm; imem_ready = 1'b1; redirect = 1'b0; irq = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ex_valid in reset", 32'(ex_valid), 32'd0);
        chk("R1 fetch addr in reset", imem_addr, 32'd0);
        rst_n = 1'b1;
        // R2 R3 fill and stream
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            chk("R2 fetch step", imem_addr, 32'(n) * st);
            if (n == 1) chk("R1 R3 empty exec after reset", 32'(ex_valid), 32'd0);
            else        chk_exec("R3 stream", 32'(n - 2) * st, hm);
        end
        // R7 stall
        imem_ready = 1'b0;
        a0 = ex_addr; f0 = imem_addr;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 ex_addr held", ex_addr, a0);
            chk("R7 fetch held", imem_addr, f0);
            chk("R7 valid held", 32'(ex_valid), 32'd1);
            chk("R10 no done in stall", 32'(ex_done), 32'd0);
        end
        imem_ready = 1'b1;
        @(negedge clk);
        chk("R7 resume", ex_addr, a0 + st);
        // R5 R6 redirect sweep over low bits
        for (int lo = 0; lo < 4; lo++) begin
            t = 32'h140 + 32'(lo) * 32'h20 + 32'(lo);
            ta = alignf(t, hm);
            redirect = 1'b1; redirect_target = t;
            chk("R10 done at redirect", 32'(ex_done), 32'd1);
            @(negedge clk);
            redirect = 1'b0;
            chk("R5 R6 fetch at aligned target", imem_addr, ta);
            chk("R5 flushed", 32'(ex_valid), 32'd0);
            @(negedge clk);
            chk("R5 still empty", 32'(ex_valid), 32'd0);
            chk("R2 fetch after target", imem_addr, ta + st);
            @(negedge clk);
            chk_exec("R5 target executes", ta, hm);
        end
        // R8 plain interrupt
        irq = 1'b1;
        chk("R8 not taken before latch", 32'(irq_take), 32'd0);
        @(negedge clk);
        irq = 1'b0;
        a0 = ex_addr;
        chk("R8 taken", 32'(irq_take), 32'd1);
        chk("R8 return addr", irq_ret, a0 + st);
        chk("R8 exec completes", 32'(ex_done), 32'd1);
        @(negedge clk);
        chk("R8 fetch vector", imem_addr, VEC);
        chk("R8 flushed", 32'(ex_valid), 32'd0);
        chk("R8 single take", 32'(irq_take), 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk_exec("R8 vector executes", VEC, hm);
        // R8 interrupt held across a stall
        irq = 1'b1; imem_ready = 1'b0;
        @(negedge clk);
        irq = 1'b0;
        a0 = ex_addr;
        chk("R8 R7 no take in stall", 32'(irq_take), 32'd0);
        @(negedge clk);
        chk("R8 R7 no take in stall 2", 32'(irq_take), 32'd0);
        imem_ready = 1'b1;
        #0;
        chk("R8 take after stall", 32'(irq_take), 32'd1);
        chk("R8 return after stall", irq_ret, a0 + st);
        @(negedge clk);
        chk("R8 vector after stall", imem_addr, VEC);
        @(negedge clk);
        @(negedge clk);
        // R9 interrupt with redirect
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        t = 32'h333;
        redirect = 1'b1; redirect_target = t;
        #0;
        chk("R9 taken with redirect", 32'(irq_take), 32'd1);
        chk("R9 return is aligned target", irq_ret, alignf(t, hm));
        @(negedge clk);
        redirect = 1'b0;
        chk("R9 fetch vector wins", imem_addr, VEC);
        chk("R9 flushed", 32'(ex_valid), 32'd0);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule